// File: doc/BRIEF.md
# Serial Mode Register Port

A write-only three-pin control port for a stereo audio converter: a serial clock, a serial data line and a latch strobe. A host shifts in 16-bit control words most significant bit first, then pulses the latch. On the latch the block decodes a 2-bit register address in the word and updates one of four mode registers. Those registers drive the converter's operating fields: the attenuation for each channel, soft mute, de-emphasis, operation enable, input word length, output mode, serial data format, word-clock polarity, attenuation linking, system clock ratio, sample-rate multiple, sample-rate group and zero-detect enable.

All three pins are asynchronous to the system clock. They pass through a synchronizer and are edge-detected in the system clock domain, which is why the host must hold the latch low and high for longer than one system clock period. A word whose bit count is not exactly 16 is discarded. Attenuation writes reach the active value only when the word's load bit is set. A link bit makes the right channel follow the left channel's attenuation.

Top module: `serial_mode_port`

## Requirements
- R1: Data bits are taken on each synchronized rising edge of the serial clock, and the first bit shifted in becomes bit 15 of the word.
- R2: A word is committed on a synchronized rising edge of the latch only when exactly 16 clock edges arrived since reset or the previous latch edge. With 15 or 17 edges the word is dropped. In every case the bit count restarts.
- R3: Bits 10:9 of the word select the register (0 left attenuation, 1 right attenuation, 2 playback, 3 format). Bits 15:11 have no effect.
- R4: Register 0 carries an attenuation value in bits 7:0 and a load bit in bit 8. With load 1 the value becomes the active left attenuation. With load 0 the active value is unchanged. Register 1 does the same for the right channel.
- R5: When the link bit is 1, the right attenuation output shows the left active value. When it is 0, the output shows the right channel's own active value.
- R6: Register 2 sets mute from bit 0, de-emphasis from bit 1, operation enable from bit 2 and the 4-bit output mode from bits 8:5.
- R7: Register 2 bits 4:3 set the word length: 00 for 16 bits, 01 for 20 bits, 10 for 24 bits. Code 11 leaves the previous length unchanged.
- R8: Register 3 sets the I2S format select from bit 0, the word-clock polarity from bit 1, the link bit from bit 2, the system clock select from bit 3 (0 gives 384 times the sample rate, 1 gives 256 times) and zero-detect enable from bit 8.
- R9: Register 3 bits 5:4 set the rate multiple (00 normal, 01 double, 10 half) and bits 7:6 set the rate group (00 for 44.1 kHz, 01 for 48 kHz, 10 for 32 kHz). Code 11 in either field leaves that field unchanged, and the other field still updates.
- R10: After reset both attenuation outputs read 0xFF and every other field reads 0.
- R11: Outputs change only on the (SYNC_STAGES+1)-th system clock edge after the latch pin rises, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial control clock (asynchronous) |
| sdat_i | input | 1 | Serial control data (asynchronous) |
| slat_i | input | 1 | Latch strobe (asynchronous) |
| att_left_o | output | 8 | Active left attenuation |
| att_right_o | output | 8 | Active right attenuation, or the left value when linked |
| mute_o | output | 1 | Soft mute |
| deemph_o | output | 1 | De-emphasis enable |
| op_en_o | output | 1 | Operation enable |
| word_len_o | output | 2 | Input word length code |
| out_mode_o | output | 4 | Output mode |
| fmt_i2s_o | output | 1 | I2S format select |
| lr_pol_o | output | 1 | Word-clock polarity |
| att_link_o | output | 1 | Attenuation link |
| sys_sel_o | output | 1 | System clock ratio select |
| rate_mult_o | output | 2 | Sample-rate multiple code |
| rate_grp_o | output | 2 | Sample-rate group code |
| zdet_en_o | output | 1 | Zero-detect enable |

## Verification
The assertions check on every cycle that no output moves except right after a commit, that the bit counter stays bounded and restarts after a commit, that the reserved length and rate codes never reach the outputs, that a load-0 write or a register-2 write leaves the attenuation alone, and that a register-2 commit puts its output mode on the port. Only the bench scenarios can show the rejection of short and long words, the most-significant-first bit order, the exact latency from the latch pin, the link mux and the reset values. The bench sweeps every output mode, length code and rate combination against an arithmetic model of the registers.

// File: rtl/mode_pkg.sv
package mode_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_LSB = 9;
  localparam int LOAD_BIT = 8;

  typedef enum logic [1:0] {
    SEL_ATT_L = 2'd0,
    SEL_ATT_R = 2'd1,
    SEL_PLAY  = 2'd2,
    SEL_FMT   = 2'd3
  } reg_sel_e;

  localparam logic [1:0] CODE_RSVD = 2'b11;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/word_framer.sv
module word_framer #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = $clog2(WORD_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              slat_i,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic              sclk_d, slat_d;
  logic              clk_rise, lat_rise;
  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;

  assign clk_rise = sclk_i & ~sclk_d;
  assign lat_rise = slat_i & ~slat_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d  <= 1'b0;
      slat_d  <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_d <= sclk_i;
      slat_d <= slat_i;
      if (lat_rise) begin
        cnt_q <= '0;
      end else if (clk_rise) begin
        shift_q <= {shift_q[WORD_W-2:0], sdat_i};
        // saturate one past full so a long word is still rejected
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign commit_o  = lat_rise && (cnt_q == CNT_FULL);
  assign word_o    = shift_q;
  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/mode_regfile.sv
module mode_regfile
  import mode_pkg::*;
#(
  parameter int          ATT_W   = 8,
  parameter logic [ATT_W-1:0] ATT_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [ATT_W-1:0] att_left_o,
  output logic [ATT_W-1:0] att_right_o,
  output logic             mute_o,
  output logic             deemph_o,
  output logic             op_en_o,
  output logic [1:0]       word_len_o,
  output logic [3:0]       out_mode_o,
  output logic             fmt_i2s_o,
  output logic             lr_pol_o,
  output logic             att_link_o,
  output logic             sys_sel_o,
  output logic [1:0]       rate_mult_o,
  output logic [1:0]       rate_grp_o,
  output logic             zdet_en_o
);
  reg_sel_e         sel;
  logic [ATT_W-1:0] att_l_q, att_r_q;

  assign sel = reg_sel_e'(word_i[ADDR_LSB+1:ADDR_LSB]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      att_l_q     <= ATT_RST;
      att_r_q     <= ATT_RST;
      mute_o      <= 1'b0;
      deemph_o    <= 1'b0;
      op_en_o     <= 1'b0;
      word_len_o  <= 2'b00;
      out_mode_o  <= 4'h0;
      fmt_i2s_o   <= 1'b0;
      lr_pol_o    <= 1'b0;
      att_link_o  <= 1'b0;
      sys_sel_o   <= 1'b0;
      rate_mult_o <= 2'b00;
      rate_grp_o  <= 2'b00;
      zdet_en_o   <= 1'b0;
    end else if (commit_i) begin
      unique case (sel)
        SEL_ATT_L: if (word_i[LOAD_BIT]) att_l_q <= word_i[ATT_W-1:0];
        SEL_ATT_R: if (word_i[LOAD_BIT]) att_r_q <= word_i[ATT_W-1:0];
        SEL_PLAY: begin
          mute_o     <= word_i[0];
          deemph_o   <= word_i[1];
          op_en_o    <= word_i[2];
          out_mode_o <= word_i[8:5];
          if (word_i[4:3] != CODE_RSVD) word_len_o <= word_i[4:3];
        end
        SEL_FMT: begin
          fmt_i2s_o  <= word_i[0];
          lr_pol_o   <= word_i[1];
          att_link_o <= word_i[2];
          sys_sel_o  <= word_i[3];
          zdet_en_o  <= word_i[8];
          if (word_i[5:4] != CODE_RSVD) rate_mult_o <= word_i[5:4];
          if (word_i[7:6] != CODE_RSVD) rate_grp_o  <= word_i[7:6];
        end
        default: ;
      endcase
    end
  end

  assign att_left_o  = att_l_q;
  assign att_right_o = att_link_o ? att_l_q : att_r_q;
endmodule

// File: rtl/serial_mode_port.sv
module serial_mode_port
  import mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ATT_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             sdat_i,
  input  logic             slat_i,
  output logic [ATT_W-1:0] att_left_o,
  output logic [ATT_W-1:0] att_right_o,
  output logic             mute_o,
  output logic             deemph_o,
  output logic             op_en_o,
  output logic [1:0]       word_len_o,
  output logic [3:0]       out_mode_o,
  output logic             fmt_i2s_o,
  output logic             lr_pol_o,
  output logic             att_link_o,
  output logic             sys_sel_o,
  output logic [1:0]       rate_mult_o,
  output logic [1:0]       rate_grp_o,
  output logic             zdet_en_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);

  logic [2:0]        pins_s;
  logic              commit;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  bit_cnt;

  pin_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({slat_i, sdat_i, sclk_i}),
    .q_o   (pins_s)
  );

  word_framer #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_framer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (pins_s[0]),
    .sdat_i   (pins_s[1]),
    .slat_i   (pins_s[2]),
    .commit_o (commit),
    .word_o   (word),
    .bit_cnt_o(bit_cnt)
  );

  mode_regfile #(.ATT_W(ATT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit),
    .word_i     (word),
    .att_left_o (att_left_o),
    .att_right_o(att_right_o),
    .mute_o     (mute_o),
    .deemph_o   (deemph_o),
    .op_en_o    (op_en_o),
    .word_len_o (word_len_o),
    .out_mode_o (out_mode_o),
    .fmt_i2s_o  (fmt_i2s_o),
    .lr_pol_o   (lr_pol_o),
    .att_link_o (att_link_o),
    .sys_sel_o  (sys_sel_o),
    .rate_mult_o(rate_mult_o),
    .rate_grp_o (rate_grp_o),
    .zdet_en_o  (zdet_en_o)
  );
endmodule

// File: rtl/serial_mode_port_chk.sv
module serial_mode_port_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5,
  parameter int ATT_W  = 8,
  parameter int CFG_W  = 34
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              commit_i,
  input logic [WORD_W-1:0] word_i,
  input logic [CNT_W-1:0]  bit_cnt_i,
  input logic [ATT_W-1:0]  att_left_i,
  input logic [ATT_W-1:0]  att_right_i,
  input logic [1:0]        word_len_i,
  input logic [3:0]        out_mode_i,
  input logic [1:0]        rate_mult_i,
  input logic [1:0]        rate_grp_i,
  input logic [CFG_W-1:0]  cfg_i
);
  a_r11_no_spurious_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_i) |-> $past(commit_i));

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_i <= CNT_W'(WORD_W + 1));

  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> bit_cnt_i == '0);

  a_r4_hold_without_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && word_i[10:9] == 2'd0 && !word_i[8] |=> $stable(att_left_i));

  a_r3_play_keeps_att: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && word_i[10:9] == 2'd2 |=> $stable(att_left_i) && $stable(att_right_i));

  a_r6_mode_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && word_i[10:9] == 2'd2 |=> out_mode_i == $past(word_i[8:5]));

  a_r7_len_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_len_i != 2'b11);

  a_r9_rate_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_mult_i != 2'b11 && rate_grp_i != 2'b11);
endmodule

bind serial_mode_port serial_mode_port_chk #(
  .WORD_W(mode_pkg::WORD_W), .CNT_W(CNT_W), .ATT_W(ATT_W), .CFG_W(2*ATT_W + 18)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .commit_i   (commit),
  .word_i     (word),
  .bit_cnt_i  (bit_cnt),
  .att_left_i (att_left_o),
  .att_right_i(att_right_o),
  .word_len_i (word_len_o),
  .out_mode_i (out_mode_o),
  .rate_mult_i(rate_mult_o),
  .rate_grp_i (rate_grp_o),
  .cfg_i      ({att_left_o, att_right_o, mute_o, deemph_o, op_en_o, word_len_o,
                out_mode_o, fmt_i2s_o, lr_pol_o, att_link_o, sys_sel_o,
                rate_mult_o, rate_grp_o, zdet_en_o})
);

// File: tb/sim_serial_mode_port.sv
module sim_serial_mode_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, slat = 1'b0;
  logic [7:0] att_l, att_r;
  logic mute, deemph, op_en, i2s, pol, link, sys, zdet;
  logic [1:0] wlen, mult, grp;
  logic [3:0] omode;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model of the register contents
  logic [7:0] e_attl = 8'hFF, e_attr = 8'hFF;
  logic e_mute = 0, e_deemph = 0, e_op = 0, e_i2s = 0, e_pol = 0, e_link = 0, e_sys = 0, e_zdet = 0;
  logic [1:0] e_wlen = 0, e_mult = 0, e_grp = 0;
  logic [3:0] e_omode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_mode_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdat_i(sdat), .slat_i(slat),
    .att_left_o(att_l), .att_right_o(att_r), .mute_o(mute), .deemph_o(deemph),
    .op_en_o(op_en), .word_len_o(wlen), .out_mode_o(omode), .fmt_i2s_o(i2s),
    .lr_pol_o(pol), .att_link_o(link), .sys_sel_o(sys), .rate_mult_o(mult),
    .rate_grp_o(grp), .zdet_en_o(zdet)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " att_left"}, 16'(att_l), 16'(e_attl));
    chk({tag, " att_right"}, 16'(att_r), 16'(e_link ? e_attl : e_attr));
    chk({tag, " mute"}, 16'(mute), 16'(e_mute));
    chk({tag, " deemph"}, 16'(deemph), 16'(e_deemph));
    chk({tag, " op_en"}, 16'(op_en), 16'(e_op));
    chk({tag, " word_len"}, 16'(wlen), 16'(e_wlen));
    chk({tag, " out_mode"}, 16'(omode), 16'(e_omode));
    chk({tag, " i2s"}, 16'(i2s), 16'(e_i2s));
    chk({tag, " polarity"}, 16'(pol), 16'(e_pol));
    chk({tag, " link"}, 16'(link), 16'(e_link));
    chk({tag, " sys_sel"}, 16'(sys), 16'(e_sys));
    chk({tag, " rate_mult"}, 16'(mult), 16'(e_mult));
    chk({tag, " rate_grp"}, 16'(grp), 16'(e_grp));
    chk({tag, " zdet"}, 16'(zdet), 16'(e_zdet));
  endtask

  task automatic model_apply(input logic [15:0] w);
    case (w[10:9])
      2'd0: if (w[8]) e_attl = w[7:0];
      2'd1: if (w[8]) e_attr = w[7:0];
      2'd2: begin
        e_mute = w[0]; e_deemph = w[1]; e_op = w[2]; e_omode = w[8:5];
        if (w[4:3] != 2'b11) e_wlen = w[4:3];
      end
      default: begin
        e_i2s = w[0]; e_pol = w[1]; e_link = w[2]; e_sys = w[3]; e_zdet = w[8];
        if (w[5:4] != 2'b11) e_mult = w[5:4];
        if (w[7:6] != 2'b11) e_grp = w[7:6];
      end
    endcase
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sdat = w[i]; sclk = 1'b0;
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic pulse_latch();
    @(negedge clk); slat = 1'b1;
    repeat (4) @(negedge clk);
    slat = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic write_word(input logic [15:0] w);
    send_bits(32'(w), 16);
    pulse_latch();
    model_apply(w);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R10 reset");

    // R11: latency from latch pin to outputs
    send_bits(32'h0401, 16);
    @(negedge clk); slat = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 before update", 16'(mute), 16'h0);
    @(negedge clk);
    chk("R11 after update", 16'(mute), 16'h1);
    repeat (3) @(negedge clk);
    slat = 1'b0;
    repeat (6) @(negedge clk);
    model_apply(16'h0401);
    check_all("R11");

    // R1: bit order, asymmetric values
    write_word(16'h0101);
    chk("R1 msb-first 01", 16'(att_l), 16'h0001);
    write_word(16'h0180);
    chk("R1 msb-first 80", 16'(att_l), 16'h0080);

    // R4: sweep attenuation on both channels
    for (int v = 0; v < 256; v += 17) begin
      write_word(16'h0100 | 16'(v));
      write_word(16'h0300 | 16'(8'hFF - v));
      check_all("R4 load");
    end
    write_word(16'h0055);
    chk("R4 no-load left", 16'(att_l), 16'(e_attl));
    write_word(16'h02AA);
    chk("R4 no-load right", 16'(att_r), 16'(e_attr));
    check_all("R4 hold");

    // R5: link on and off
    write_word(16'h0142);
    write_word(16'h0324);
    write_word(16'h0604);
    chk("R5 linked", 16'(att_r), 16'h0042);
    check_all("R5 linked");
    write_word(16'h0600);
    chk("R5 unlinked", 16'(att_r), 16'h0024);

    // R6: output mode and the three flag bits
    for (int m = 0; m < 16; m++) begin
      write_word(16'h0400 | 16'(m << 5) | 16'(m & 7));
      check_all("R6");
    end

    // R7: every length code, reserved keeps previous
    for (int c = 0; c < 4; c++) begin
      write_word(16'h0400 | 16'(c << 3));
      check_all("R7");
    end
    write_word(16'h0408);
    write_word(16'h0418);
    chk("R7 reserved keeps 20-bit", 16'(wlen), 16'h1);

    // R9: all multiple/group combinations
    for (int g = 0; g < 4; g++) begin
      for (int m = 0; m < 4; m++) begin
        write_word(16'h0600 | 16'(g << 6) | 16'(m << 4));
        check_all("R9");
      end
    end

    // R8: single-bit format fields
    for (int b = 0; b < 16; b++) begin
      write_word(16'h0600 | 16'(b & 3) | 16'(((b >> 2) & 1) << 3) | 16'(((b >> 3) & 1) << 8));
      check_all("R8");
    end

    // R3: reserved upper bits ignored, address still decoded
    write_word(16'hFC00 | 16'h01E3);
    check_all("R3 reg2");
    write_word(16'hF800 | 16'h0177);
    check_all("R3 reg0");
    write_word(16'hA800 | 16'h0399);
    check_all("R3 reg1");

    // R2: short and long words are dropped
    send_bits(32'h0000_05E7, 15);
    pulse_latch();
    check_all("R2 short");
    send_bits(32'h0001_05E7, 17);
    pulse_latch();
    check_all("R2 long");
    write_word(16'h05E7);
    check_all("R2 full after reject");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule